// File: doc/BRIEF.md
# Warm/Cold Reset Sequencer with Acknowledge Timeout

This block takes reset requests from elsewhere in the chip and decides how each one is served. A cold request always gives a cold reset. A warm request gives a warm reset only when warm resets are enabled. A warm reset first asks the memory controller to reach a safe stopping point. The block then waits for the controller's acknowledge before it drives the warm reset output. A slow tick enable of about 32 kHz paces a timeout counter that bounds this wait. If the acknowledge has not come by the end of the selected window, the sequence turns into a cold reset.

After a warm or a cold reset pulse, the block drives a peripheral reset. The width of that reset is a configurable multiple of a base unit of system clock cycles. The block then goes back to waiting for requests. A request that arrives while a sequence is running is dropped. The one exception is a cold request during the acknowledge wait, which takes over the sequence at once.

Top module: `warm_cold_rst_seq`

## Requirements
- R1: With `warm_en_i` = 0, a warm request gives a cold reset, and `mem_stop_req_o` is never raised.
- R2: When idle, a cold request raises `cold_rst_o` in the next cycle. A cold request always wins over a warm request in the same cycle.
- R3: When idle with `warm_en_i` = 1, a warm request raises `mem_stop_req_o` in the next cycle. An acknowledge seen during the wait raises `warm_rst_o` in the next cycle.
- R4: The timeout window depends on `bypass_sel_i`. Value 1 times out on the 16th pulse of `slow_tick_i` in the wait, value 2 on the 32nd and value 3 on the 64th. Only tick pulses advance the count. The timeout gives a cold reset in the next cycle. An acknowledge in the same cycle as the final tick gives a warm reset instead.
- R5: With `bypass_sel_i` = 0, the wait never times out, however many ticks arrive.
- R6: A cold request during the acknowledge wait drops `mem_stop_req_o` and raises `cold_rst_o` in the next cycle.
- R7: `warm_rst_o` and `cold_rst_o` each stay high for exactly 4 consecutive cycles. The peripheral reset follows at once.
- R8: `periph_rst_o` stays high for (`stretch_sel_i` + 1) × 88 cycles. The value used is the one sampled when the stretch starts. The block then returns to idle.
- R9: Warm and cold requests that arrive during a reset pulse or during the stretch are dropped. They have no effect after the block returns to idle.
- R10: In reset all outputs are 0, and at most one of `warm_rst_o`, `cold_rst_o` and `periph_rst_o` is high at any time.
- R11: `mem_stop_req_o` stays high through the warm reset pulse and falls when the stretch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| warm_req_i | input | 1 | Warm reset request |
| cold_req_i | input | 1 | Cold reset request |
| mem_ack_i | input | 1 | Memory controller safe-stop acknowledge |
| slow_tick_i | input | 1 | One-cycle pulse at the slow 32 kHz rate |
| warm_en_i | input | 1 | 1 serves warm requests as warm, 0 turns them into cold |
| bypass_sel_i | input | 2 | Acknowledge timeout: 0 none, 1/2/3 = 16/32/64 ticks |
| stretch_sel_i | input | 2 | Peripheral reset width select, (value+1)×88 cycles |
| mem_stop_req_o | output | 1 | Request to the memory controller to stop safely |
| warm_rst_o | output | 1 | Warm reset pulse |
| cold_rst_o | output | 1 | Cold reset pulse |
| periph_rst_o | output | 1 | Stretched peripheral reset |

## Verification
A wrong sequencer state shows at the ports within one cycle. Every state has its own output pattern, so a bad transition gives the wrong output one edge after the request, the acknowledge or the tick that caused it. A miscounting timeout counter shows only at the final tick of the window: the cold pulse comes too early or too late. A wrong span counter changes the measured length of a reset pulse or of the stretch, and that shows when the pulse ends. The bench also repeats sequences with ticks spread out, so that a counter that advanced on something other than a tick would time out at the wrong pulse.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        RSQ_IDLE     = 3'd0,
        RSQ_WAIT_ACK = 3'd1,
        RSQ_WARM     = 3'd2,
        RSQ_COLD     = 3'd3,
        RSQ_STRETCH  = 3'd4
    } rsq_state_e;

    typedef struct packed {
        rsq_state_e state;
        logic [1:0] stretch_sel;
    } rsq_ctrl_t;

endpackage

// File: rtl/rsq_ack_timer.sv
module rsq_ack_timer #(
    parameter int BASE_TICKS = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic       active_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);
    localparam int MAX_TICKS = BASE_TICKS * 4;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        case (sel_i)
            2'd1:    limit = CW'(BASE_TICKS);
            2'd2:    limit = CW'(BASE_TICKS * 2);
            2'd3:    limit = CW'(MAX_TICKS);
            default: limit = '0;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (active_i && tick_i && (cnt_q != {CW{1'b1}})) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expire_o = active_i && tick_i && (sel_i != 2'd0) && (cnt_q == limit - CW'(1));

    AST_TICK_ONLY_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !tick_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/rsq_span_timer.sv
module rsq_span_timer #(
    parameter int CW = 9
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)    cnt_d = '0;
        else if (run_i) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == limit_i - CW'(1));

endmodule

// File: rtl/warm_cold_rst_seq.sv
module warm_cold_rst_seq
    import rsq_pkg::*;
#(
    parameter int HOLD_CYCLES   = 4,
    parameter int STRETCH_UNIT  = 88,
    parameter int BASE_TICKS    = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       warm_req_i,
    input  logic       cold_req_i,
    input  logic       mem_ack_i,
    input  logic       slow_tick_i,
    input  logic       warm_en_i,
    input  logic [1:0] bypass_sel_i,
    input  logic [1:0] stretch_sel_i,
    output logic       mem_stop_req_o,
    output logic       warm_rst_o,
    output logic       cold_rst_o,
    output logic       periph_rst_o
);
    localparam int SPAN_MAX = (4 * STRETCH_UNIT > HOLD_CYCLES) ? 4 * STRETCH_UNIT : HOLD_CYCLES;
    localparam int SPAN_W   = $clog2(SPAN_MAX + 1);

    rsq_ctrl_t ctrl_d, ctrl_q;
    logic      ack_expire, span_done, span_clear, span_run;
    logic [SPAN_W-1:0] span_limit, stretch_len;

    always_comb begin
        stretch_len = SPAN_W'(32'(ctrl_q.stretch_sel) + 32'd1) * SPAN_W'(STRETCH_UNIT);
        span_limit  = (ctrl_q.state == RSQ_STRETCH) ? stretch_len : SPAN_W'(HOLD_CYCLES);
        span_run    = (ctrl_q.state == RSQ_WARM) || (ctrl_q.state == RSQ_COLD) ||
                      (ctrl_q.state == RSQ_STRETCH);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_q.state)
            RSQ_IDLE: begin
                if (cold_req_i) begin
                    ctrl_d.state = RSQ_COLD;
                end else if (warm_req_i) begin
                    ctrl_d.state = warm_en_i ? RSQ_WAIT_ACK : RSQ_COLD;
                end
            end
            RSQ_WAIT_ACK: begin
                if (cold_req_i)      ctrl_d.state = RSQ_COLD;
                else if (mem_ack_i)  ctrl_d.state = RSQ_WARM;
                else if (ack_expire) ctrl_d.state = RSQ_COLD;
            end
            RSQ_WARM, RSQ_COLD: begin
                if (span_done) begin
                    ctrl_d.state       = RSQ_STRETCH;
                    ctrl_d.stretch_sel = stretch_sel_i;
                end
            end
            RSQ_STRETCH: begin
                if (span_done) ctrl_d.state = RSQ_IDLE;
            end
            default: ctrl_d.state = RSQ_IDLE;
        endcase
        span_clear = (ctrl_d.state != ctrl_q.state);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.state       <= RSQ_IDLE;
            ctrl_q.stretch_sel <= 2'd0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    rsq_ack_timer #(.BASE_TICKS(BASE_TICKS)) i_ack_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (ctrl_q.state != RSQ_WAIT_ACK),
        .active_i (ctrl_q.state == RSQ_WAIT_ACK),
        .tick_i   (slow_tick_i),
        .sel_i    (bypass_sel_i),
        .expire_o (ack_expire)
    );

    rsq_span_timer #(.CW(SPAN_W)) i_span_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (span_clear),
        .run_i   (span_run),
        .limit_i (span_limit),
        .done_o  (span_done)
    );

    assign mem_stop_req_o = (ctrl_q.state == RSQ_WAIT_ACK) || (ctrl_q.state == RSQ_WARM);
    assign warm_rst_o     = (ctrl_q.state == RSQ_WARM);
    assign cold_rst_o     = (ctrl_q.state == RSQ_COLD);
    assign periph_rst_o   = (ctrl_q.state == RSQ_STRETCH);

    AST_ONE_RESET_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({warm_rst_o, cold_rst_o, periph_rst_o})); // R10
    AST_STOP_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_stop_req_o) |-> $past(warm_en_i)); // R1
    AST_WARM_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(warm_rst_o) |-> $past(mem_ack_i)); // R3
    AST_COLD_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cold_rst_o) |-> $past(cold_rst_o, 4)); // R7
    AST_WARM_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(warm_rst_o) |-> $past(warm_rst_o, 4)); // R7
    AST_STRETCH_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(warm_rst_o) || $fell(cold_rst_o)) |-> periph_rst_o); // R8
    AST_MEM_HELD_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm_rst_o |-> mem_stop_req_o); // R11
    AST_COLD_ABORTS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_stop_req_o && !warm_rst_o && cold_req_i) |=> (cold_rst_o && !mem_stop_req_o)); // R6

endmodule

// File: tb/test_warm_cold_rst_seq.sv
module test_warm_cold_rst_seq;
    localparam int HOLD = 4;
    localparam int UNIT = 88;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic warm_req_i = 1'b0, cold_req_i = 1'b0, mem_ack_i = 1'b0, slow_tick_i = 1'b0;
    logic warm_en_i = 1'b1;
    logic [1:0] bypass_sel_i = 2'd0, stretch_sel_i = 2'd0;
    logic mem_stop_req_o, warm_rst_o, cold_rst_o, periph_rst_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R10";

    always #4 clk_i = ~clk_i;

    warm_cold_rst_seq i_warm_cold_rst_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .warm_req_i(warm_req_i), .cold_req_i(cold_req_i),
        .mem_ack_i(mem_ack_i), .slow_tick_i(slow_tick_i), .warm_en_i(warm_en_i),
        .bypass_sel_i(bypass_sel_i), .stretch_sel_i(stretch_sel_i),
        .mem_stop_req_o(mem_stop_req_o), .warm_rst_o(warm_rst_o),
        .cold_rst_o(cold_rst_o), .periph_rst_o(periph_rst_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Behavioural reference: mode 0 idle, 1 waiting for ack, 2 warm, 3 cold, 4 stretch
    int m_mode = 0, m_cnt = 0, m_ticks = 0, m_width = 0;
    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_mode = 0; m_cnt = 0; m_ticks = 0; m_width = 0;
        end else begin
            case (m_mode)
                0: begin
                    if (cold_req_i) begin m_mode = 3; m_cnt = 0; end
                    else if (warm_req_i) begin
                        if (warm_en_i) begin m_mode = 1; m_ticks = 0; end
                        else begin m_mode = 3; m_cnt = 0; end
                    end
                end
                1: begin
                    if (cold_req_i) begin m_mode = 3; m_cnt = 0; end
                    else if (mem_ack_i) begin m_mode = 2; m_cnt = 0; end
                    else if (slow_tick_i) begin
                        m_ticks++;
                        if (bypass_sel_i != 0 && m_ticks == (8 << bypass_sel_i)) begin
                            m_mode = 3; m_cnt = 0;
                        end
                    end
                end
                2, 3: begin
                    m_cnt++;
                    if (m_cnt == HOLD) begin
                        m_mode = 4; m_cnt = 0; m_width = (int'(stretch_sel_i) + 1) * UNIT;
                    end
                end
                default: begin
                    m_cnt++;
                    if (m_cnt == m_width) m_mode = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison against the reference, plus pulse-length monitors
    int len_w = 0, len_c = 0, len_p = 0;
    always @(negedge clk_i) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
        if (rst_ni) begin
            check({cur_req, " mem_stop"}, int'(mem_stop_req_o), int'(m_mode == 1 || m_mode == 2));
            check({cur_req, " warm_rst"}, int'(warm_rst_o), int'(m_mode == 2));
            check({cur_req, " cold_rst"}, int'(cold_rst_o), int'(m_mode == 3));
            check({cur_req, " periph_rst"}, int'(periph_rst_o), int'(m_mode == 4));
            if (warm_rst_o) len_w++;
            else if (len_w > 0) begin check("R7 warm width", len_w, HOLD); len_w = 0; end
            if (cold_rst_o) len_c++;
            else if (len_c > 0) begin check("R7 cold width", len_c, HOLD); len_c = 0; end
            if (periph_rst_o) len_p++;
            else if (len_p > 0) begin
                check("R8 stretch width", len_p, (int'(stretch_sel_i) + 1) * UNIT);
                len_p = 0;
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (m_mode == 0 && !mem_stop_req_o && !warm_rst_o && !cold_rst_o && !periph_rst_o) break;
            step();
        end
        step(2);
    endtask

    task automatic req_warm();
        step(); warm_req_i = 1'b1; step(); warm_req_i = 1'b0;
    endtask

    task automatic req_cold();
        step(); cold_req_i = 1'b1; step(); cold_req_i = 1'b0;
    endtask

    task automatic send_ticks(int n);
        for (int i = 0; i < n; i++) begin
            step(); slow_tick_i = 1'b1; step(); slow_tick_i = 1'b0; step();
        end
    endtask

    task automatic timeout_case(logic [1:0] sel, int n);
        bypass_sel_i = sel; warm_en_i = 1'b1;
        req_warm();
        send_ticks(n - 1);
        check("R4 waiting before last tick", int'(mem_stop_req_o), 1);
        check("R4 no early cold", int'(cold_rst_o), 0);
        step(); slow_tick_i = 1'b1; step(); slow_tick_i = 1'b0;
        check("R4 cold after timeout", int'(cold_rst_o), 1);
        check("R4 stop released", int'(mem_stop_req_o), 0);
        wait_idle();
    endtask

    initial begin
        step(2);
        check("R10 reset mem_stop", int'(mem_stop_req_o), 0);
        check("R10 reset warm", int'(warm_rst_o), 0);
        check("R10 reset cold", int'(cold_rst_o), 0);
        check("R10 reset periph", int'(periph_rst_o), 0);
        rst_ni = 1'b1;
        step(2);

        cur_req = "R2";
        req_cold();
        check("R2 cold next cycle", int'(cold_rst_o), 1);
        wait_idle();
        step(); cold_req_i = 1'b1; warm_req_i = 1'b1; step(); cold_req_i = 1'b0; warm_req_i = 1'b0;
        check("R2 cold wins", int'(cold_rst_o), 1);
        check("R2 no stop req", int'(mem_stop_req_o), 0);
        wait_idle();

        cur_req = "R1";
        warm_en_i = 1'b0;
        req_warm();
        check("R1 disabled warm gives cold", int'(cold_rst_o), 1);
        check("R1 no stop req", int'(mem_stop_req_o), 0);
        wait_idle();

        cur_req = "R3";
        warm_en_i = 1'b1; bypass_sel_i = 2'd1;
        req_warm();
        check("R3 stop req raised", int'(mem_stop_req_o), 1);
        step(5);
        check("R3 still waiting", int'(mem_stop_req_o), 1);
        step(); mem_ack_i = 1'b1; step(); mem_ack_i = 1'b0;
        check("R3 warm after ack", int'(warm_rst_o), 1);
        cur_req = "R11";
        check("R11 stop held in warm", int'(mem_stop_req_o), 1);
        step(3);
        check("R11 stop held to last warm cycle", int'(mem_stop_req_o), 1);
        step();
        check("R11 stop released in stretch", int'(mem_stop_req_o), 0);
        check("R11 stretch started", int'(periph_rst_o), 1);
        wait_idle();

        cur_req = "R4";
        timeout_case(2'd1, 16);
        timeout_case(2'd2, 32);
        timeout_case(2'd3, 64);

        bypass_sel_i = 2'd1;
        req_warm();
        send_ticks(15);
        step(); slow_tick_i = 1'b1; mem_ack_i = 1'b1; step(); slow_tick_i = 1'b0; mem_ack_i = 1'b0;
        check("R4 ack wins final tick", int'(warm_rst_o), 1);
        check("R4 no cold on tie", int'(cold_rst_o), 0);
        wait_idle();

        cur_req = "R5";
        bypass_sel_i = 2'd0;
        req_warm();
        send_ticks(100);
        check("R5 still waiting", int'(mem_stop_req_o), 1);
        check("R5 no cold", int'(cold_rst_o), 0);
        step(); mem_ack_i = 1'b1; step(); mem_ack_i = 1'b0;
        check("R5 warm after long wait", int'(warm_rst_o), 1);
        wait_idle();

        cur_req = "R6";
        bypass_sel_i = 2'd3;
        req_warm();
        send_ticks(3);
        req_cold();
        check("R6 cold takes over", int'(cold_rst_o), 1);
        check("R6 stop dropped", int'(mem_stop_req_o), 0);
        wait_idle();

        cur_req = "R8";
        for (int s = 0; s < 4; s++) begin
            stretch_sel_i = 2'(s);
            req_cold();
            wait_idle();
        end

        cur_req = "R9";
        stretch_sel_i = 2'd0; bypass_sel_i = 2'd1;
        req_cold();
        step(); warm_req_i = 1'b1; step(); warm_req_i = 1'b0;
        step(10);
        check("R9 in stretch", int'(periph_rst_o), 1);
        req_warm();
        req_cold();
        wait_idle();
        check("R9 no stop req afterwards", int'(mem_stop_req_o), 0);
        check("R9 no cold afterwards", int'(cold_rst_o), 0);
        check("R9 no warm afterwards", int'(warm_rst_o), 0);

        step(4);
        finish_run();
    end
endmodule